// File: doc/BRIEF.md
# ISA Bus Clock Divider and I/O Recovery Timer

This block derives the ISA bus clock from the 33 MHz host clock. It produces a one-host-cycle enable pulse, `busClkEn`, once per bus-clock period. The period in host cycles comes from three sources:

- a slow ratio of four or three;
- a fast ratio of two or one, used when the current cycle falls in a fast range;
- an optional power-down multiplier.

A new ratio is latched only at a bus-clock boundary, so no period is ever cut short.

The same block times the recovery gap that must follow each 8-bit or 16-bit I/O cycle. The gap has a base of 3.5 bus clocks and an optional programmable extra. It is counted in half bus-clock units and converted to host cycles using the period in force. `recovBusy` stays high for the whole gap.

The sequencer that issues ISA commands pulses `ioDone` at the end of each I/O cycle and waits for `recovBusy` to fall before starting the next one.

Top module: `isa_busclk_timer`

## Requirements
- R1: While `rst_n` is low, `busClkEn` and `recovBusy` are low. After release, the first `busClkEn` pulse appears in the fourth host cycle, because the reset clock setting selects divide-by-four.
- R2: Outside fast mode and power-down division, `clkCtrl[7]`=0 gives one `busClkEn` pulse every 4 host cycles, and `clkCtrl[7]`=1 gives one every 3 host cycles.
- R3: A cycle runs in fast mode when any of these holds: `fastCtrl[4]` is set; `fastCtrl[5]` and `rangeHit[0]` are both set; `fastCtrl[6]` and `rangeHit[1]` are both set. Otherwise the slow ratio applies.
- R4: In fast mode the period is 1 host cycle when `fastCtrl[3]`=1 and 2 host cycles when `fastCtrl[3]`=0.
- R5: `pdDiv` codes 1 to 6 multiply the period by 2, 4, 8, 16, 32 and 64. Code 0 adds no division.
- R6: `pdDiv`=7 stops the bus clock, so no `busClkEn` pulse occurs. Returning to another code restarts the clock at once.
- R7: A change of ratio takes effect only at a bus-clock boundary. The period already under way completes at its old length.
- R8: For an 8-bit cycle (`ioWide`=0), recovery is 7 half bus clocks plus 2×`clkCtrl[5:3]` half bus clocks when `clkCtrl[6]`=1. When `clkCtrl[6]`=0 it is 7 half bus clocks.
- R9: For a 16-bit cycle (`ioWide`=1), recovery is 7 half bus clocks plus twice an extra count when `clkCtrl[2]`=1. `clkCtrl[1:0]` codes 01, 10 and 11 give an extra of 1, 2 and 3, and code 00 gives 4. When `clkCtrl[2]`=0 there is no extra.
- R10: After an `ioDone` pulse, `recovBusy` is high for exactly ceil(halves × period / 2) host cycles. The period used is the one in force, and the recovery fields are those latched at the last bus-clock boundary.
- R11: Until the first bus-clock boundary after reset, recovery uses the clock-control reset value 0x4D with a 4-cycle period.
- R12: An `ioDone` pulse while `recovBusy` is high restarts the recovery count from its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| clkCtrl | input | 8 | Clock-control byte: slow ratio and recovery fields |
| fastCtrl | input | 8 | Fast-mode control byte: fast ratio, global and per-range enables |
| rangeHit | input | 2 | Current cycle hits decoder range 1 (bit 0) or range 2 (bit 1) |
| pdDiv | input | 3 | Power-down extra division code |
| ioDone | input | 1 | One-cycle pulse marking the end of an I/O cycle |
| ioWide | input | 1 | Width of the ending cycle: 1 = 16-bit, 0 = 8-bit |
| busClkEn | output | 1 | One-host-cycle pulse per bus-clock period |
| recovBusy | output | 1 | High while the recovery gap runs |

## Verification
The bench builds the block with its default parameters: ratios of 4, 3, 2 and 1, and a 3-bit power-down field. With these values, the period length that the deepest division (256 host cycles) gives and the longest recovery counts are within reach in a short run. The odd divide-by-three and divide-by-one periods test the rounding of half-clock recovery lengths. Directed cases cover the period that runs right after reset, a ratio change in the middle of a period, the stopped clock, and a recovery that is restarted.

// File: rtl/isa_busclk_pkg.sv
package isa_busclk_pkg;
  parameter int SLOW_DIV_EVEN = 4;
  parameter int SLOW_DIV_ODD  = 3;
  parameter int FAST_DIV_HALF = 2;
  parameter int FAST_DIV_FULL = 1;
  parameter int PD_W          = 3;
  parameter int EXTRA_W       = 3;
  parameter int BASE_HALVES   = 7;
  parameter logic [7:0] CFG_RESET = 8'h4D;

  localparam int PD_CODES     = 2 ** PD_W;
  localparam int PD_MAX_SHIFT = PD_CODES - 2;
  localparam int MAX_PERIOD   = SLOW_DIV_EVEN << PD_MAX_SHIFT;
  localparam int PER_W        = $clog2(MAX_PERIOD + 1);
  localparam int MAX_EXTRA    = 2 ** EXTRA_W - 1;
  localparam int MAX_HALVES   = BASE_HALVES + 2 * MAX_EXTRA;
  localparam int HALF_W       = $clog2(MAX_HALVES + 1);
  localparam int MAX_LEN      = (MAX_HALVES * MAX_PERIOD + 1) / 2;
  localparam int REC_W        = $clog2(MAX_LEN + 1);
  localparam int MUL_W        = HALF_W + PER_W;
  localparam int FIRST_PERIOD = CFG_RESET[7] ? SLOW_DIV_ODD : SLOW_DIV_EVEN;

  typedef struct packed {
    logic              stopClk;
    logic [PER_W-1:0]  nextPeriod;
    logic              loadRecov;
    logic [REC_W-1:0]  recovLen;
  } cmdBus_t;
endpackage

// File: rtl/isa_busclk_ctrl.sv
module isa_busclk_ctrl
  import isa_busclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       clkCtrl,
  input  logic [7:0]       fastCtrl,
  input  logic [1:0]       rangeHit,
  input  logic [PD_W-1:0]  pdDiv,
  input  logic             ioDone,
  input  logic             ioWide,
  input  logic             tick,
  input  logic [PER_W-1:0] curPeriod,
  output cmdBus_t          cmd
);
  logic [7:0]       cfgShadow;
  logic             fastHit;
  logic [PER_W-1:0] baseDiv;
  logic [PER_W-1:0] scaled [PD_CODES];
  logic             stopClk;
  logic [EXTRA_W-1:0] extra;
  logic [HALF_W-1:0]  halves;
  logic [MUL_W-1:0]   product;
  logic               unusedBits;

  assign unusedBits = ^{fastCtrl[7], fastCtrl[2:0], cfgShadow[7]};

  // Recovery settings are captured at each bus-clock boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfgShadow <= CFG_RESET;
    else if (tick) cfgShadow <= clkCtrl;
  end

  // Fast-mode selection and base ratio.
  always_comb begin
    fastHit = fastCtrl[4] | (fastCtrl[5] & rangeHit[0]) | (fastCtrl[6] & rangeHit[1]);
    if (fastHit) baseDiv = fastCtrl[3] ? PER_W'(FAST_DIV_FULL) : PER_W'(FAST_DIV_HALF);
    else         baseDiv = clkCtrl[7]  ? PER_W'(SLOW_DIV_ODD)  : PER_W'(SLOW_DIV_EVEN);
  end

  // Power-down scaled candidates, one per code; the top code stops the clock.
  for (genvar g = 0; g < PD_CODES; g++) begin : g_scale
    if (g <= PD_MAX_SHIFT) begin : g_div
      assign scaled[g] = baseDiv << g;
    end else begin : g_stop
      assign scaled[g] = '0;
    end
  end

  assign stopClk = (pdDiv == PD_W'(PD_CODES - 1));

  // Recovery length in half bus clocks, then in host cycles.
  always_comb begin
    if (ioWide) begin
      if (cfgShadow[2]) extra = (cfgShadow[1:0] == 2'b00) ? EXTRA_W'(4) : EXTRA_W'(cfgShadow[1:0]);
      else              extra = '0;
    end else begin
      extra = cfgShadow[6] ? EXTRA_W'(cfgShadow[5:3]) : '0;
    end
    halves  = HALF_W'(BASE_HALVES) + HALF_W'({extra, 1'b0});
    product = MUL_W'(halves) * MUL_W'(curPeriod);
  end

  always_comb begin
    cmd.stopClk    = stopClk;
    cmd.nextPeriod = stopClk ? scaled[0] : scaled[pdDiv];
    cmd.loadRecov  = ioDone;
    cmd.recovLen   = REC_W'((product + MUL_W'(1)) >> 1);
  end
endmodule

// File: rtl/isa_busclk_dp.sv
module isa_busclk_dp
  import isa_busclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cmdBus_t          cmd,
  output logic             tick,
  output logic [PER_W-1:0] curPeriod,
  output logic             busy
);
  logic [PER_W-1:0] phaseCnt;
  logic [REC_W-1:0] recCnt;

  assign tick = (phaseCnt == '0) && !cmd.stopClk;
  assign busy = (recCnt != '0);

  // Period counter: a new ratio is latched only when a period ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt  <= PER_W'(FIRST_PERIOD - 1);
      curPeriod <= PER_W'(FIRST_PERIOD);
    end else if (phaseCnt != '0) begin
      phaseCnt  <= phaseCnt - 1'b1;
    end else if (!cmd.stopClk) begin
      phaseCnt  <= cmd.nextPeriod - 1'b1;
      curPeriod <= cmd.nextPeriod;
    end
  end

  // Recovery counter: reloaded on every end-of-cycle pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             recCnt <= '0;
    else if (cmd.loadRecov) recCnt <= cmd.recovLen;
    else if (recCnt != '0)  recCnt <= recCnt - 1'b1;
  end
endmodule

// File: rtl/isa_busclk_timer.sv
module isa_busclk_timer
  import isa_busclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      clkCtrl,
  input  logic [7:0]      fastCtrl,
  input  logic [1:0]      rangeHit,
  input  logic [PD_W-1:0] pdDiv,
  input  logic            ioDone,
  input  logic            ioWide,
  output logic            busClkEn,
  output logic            recovBusy
);
  cmdBus_t          cmd;
  logic             tick;
  logic [PER_W-1:0] curPeriod;

  isa_busclk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkCtrl(clkCtrl), .fastCtrl(fastCtrl),
    .rangeHit(rangeHit), .pdDiv(pdDiv), .ioDone(ioDone), .ioWide(ioWide),
    .tick(tick), .curPeriod(curPeriod), .cmd(cmd)
  );

  isa_busclk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick(tick),
    .curPeriod(curPeriod), .busy(recovBusy)
  );

  assign busClkEn = tick;
endmodule

// File: rtl/isa_busclk_chk.sv
module isa_busclk_chk
  import isa_busclk_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      fastCtrl,
  input logic [1:0]      rangeHit,
  input logic [PD_W-1:0] pdDiv,
  input logic            ioDone,
  input logic            busClkEn,
  input logic            recovBusy
);
  // R10
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ioDone |=> recovBusy);

  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovBusy) |-> $past(ioDone));

  // R10
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovBusy) |=> recovBusy);

  // R6
  stopped_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdDiv == PD_W'(PD_CODES - 1)) |-> !busClkEn);

  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busClkEn && $past(busClkEn)) |->
      ($past(pdDiv) == '0 && $past(fastCtrl[3]) &&
       ($past(fastCtrl[4]) || ($past(fastCtrl[5]) && $past(rangeHit[0])) ||
        ($past(fastCtrl[6]) && $past(rangeHit[1])))));
endmodule

bind isa_busclk_timer isa_busclk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fastCtrl(fastCtrl), .rangeHit(rangeHit),
  .pdDiv(pdDiv), .ioDone(ioDone), .busClkEn(busClkEn), .recovBusy(recovBusy)
);

// File: tb/tb_isa_busclk_timer.sv
module tb_isa_busclk_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clkCtrl = 8'h00;
  logic [7:0] fastCtrl = 8'h00;
  logic [1:0] rangeHit = 2'b00;
  logic [2:0] pdDiv = 3'd0;
  logic       ioDone = 1'b0;
  logic       ioWide = 1'b0;
  logic       busClkEn, recovBusy;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  isa_busclk_timer dut (
    .clk(clk), .rst_n(rst_n), .clkCtrl(clkCtrl), .fastCtrl(fastCtrl),
    .rangeHit(rangeHit), .pdDiv(pdDiv), .ioDone(ioDone), .ioWide(ioWide),
    .busClkEn(busClkEn), .recovBusy(recovBusy)
  );

  // fields: [31:24] clkCtrl, [23:16] fastCtrl, [9:8] rangeHit, [6:4] pdDiv, [0] ioWide
  localparam int NVEC = 14;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h8000_0000, 32'h0000_0000, 32'hF800_0000, 32'h0400_0001,
    32'h0700_0001, 32'h0010_0000, 32'h0018_0000, 32'h0020_0100,
    32'h0020_0200, 32'h0048_0200, 32'h8000_0030, 32'h0000_0060,
    32'h4400_0000, 32'h4400_0001 };
  localparam string VTAG [NVEC] = '{
    "R2", "R2", "R8", "R9", "R9", "R3", "R4", "R3", "R3", "R3", "R5", "R5", "R8", "R9" };

  function automatic int expPeriod(logic [7:0] c, logic [7:0] f, logic [1:0] h, logic [2:0] p);
    bit fast = f[4] || (f[5] && h[0]) || (f[6] && h[1]);
    int b = fast ? (f[3] ? 1 : 2) : (c[7] ? 3 : 4);
    return b << p;
  endfunction

  function automatic int expRecov(logic [7:0] c, logic w, int per);
    int x = 0;
    if (w) begin
      if (c[2]) x = (c[1:0] == 2'b00) ? 4 : int'(c[1:0]);
    end else if (c[6]) x = int'(c[5:3]);
    return ((7 + 2 * x) * per + 1) / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!busClkEn);
  endtask

  task automatic countPeriod(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!busClkEn);
  endtask

  task automatic countBusy(input logic w, output int n);
    ioWide = w; ioDone = 1'b1;
    @(negedge clk); ioDone = 1'b0;
    n = 0;
    while (recovBusy) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, per, rec, en;
    // R1: outputs low while reset is held
    repeat (3) @(negedge clk);
    chk("R1 enable in reset", int'(busClkEn), 0);
    chk("R1 busy in reset", int'(recovBusy), 0);
    // release; R11: pulse before the first boundary uses reset settings
    rst_n = 1'b1; ioWide = 1'b0; ioDone = 1'b1;
    @(negedge clk); ioDone = 1'b0;
    n = 0; en = 0;
    for (int i = 1; i <= 3; i++) begin
      if (busClkEn && en == 0) en = i;
      if (recovBusy) n++;
      if (i < 3) @(negedge clk);
    end
    chk("R1 first enable cycle", en, 3);
    while (recovBusy) begin @(negedge clk); n++; end
    n--;
    chk("R11 reset-setting recovery", n, 18);

    // table of configurations
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e = VEC[v];
      clkCtrl = e[31:24]; fastCtrl = e[23:16]; rangeHit = e[9:8]; pdDiv = e[6:4];
      waitTick();
      countPeriod(per);
      chk({VTAG[v], " period"}, per, expPeriod(e[31:24], e[23:16], e[9:8], e[6:4]));
      countBusy(e[0], rec);
      chk({VTAG[v], " R10 recovery"}, rec,
          expRecov(e[31:24], e[0], expPeriod(e[31:24], e[23:16], e[9:8], e[6:4])));
    end

    // R7: ratio change mid-period waits for the boundary
    clkCtrl = 8'h00; fastCtrl = 8'h00; rangeHit = 2'b00; pdDiv = 3'd0;
    waitTick(); waitTick();
    @(negedge clk); fastCtrl = 8'h18;
    n = 1;
    do begin @(negedge clk); n++; end while (!busClkEn);
    chk("R7 old period completes", n, 4);
    countPeriod(n);
    chk("R7 new period after boundary", n, 1);
    fastCtrl = 8'h00;

    // R6: stopped clock
    waitTick();
    pdDiv = 3'd7; en = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (busClkEn) en++; end
    chk("R6 no enables while stopped", en, 0);
    pdDiv = 3'd0; #1;
    chk("R6 restart enable", int'(busClkEn), 1);

    // R12: restart of recovery while busy
    waitTick(); waitTick();
    ioWide = 1'b0; ioDone = 1'b1;
    @(negedge clk); ioDone = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 busy before restart", int'(recovBusy), 1);
    countBusy(1'b0, rec);
    chk("R12 restarted length", rec, 14);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule